// File: doc/BRIEF.md
# Modulo Real-Time Tick Counter

This block is a small timer peripheral. It counts prescaled ticks taken from one of three clock-enable strobes, each one system-clock cycle wide and synchronous to the system clock: a slow low-power tick, an external tick and a fast internal tick. An 8-bit up counter advances once per prescaler period. When an advance finds the counter equal to the modulo value, the counter returns to 0 and a sticky match flag is raised. An interrupt output follows the flag whenever the interrupt is enabled.

Software reaches the block through a simple byte-wide register bus. The bus has a write strobe, a 2-bit address, write data and combinational read data. There are three registers: a control/status byte, a read-only counter byte and a modulo byte. A typical use is a millisecond delay. Software selects the low-power source with the divide-by-1 decimal code and then waits for the counter value to change.

Top module: `rtick_timer`

## Requirements
- R1: After reset, control reads 0x00, counter reads 0x00, modulo reads 0xFF and irq is 0.
- R2: The address map is 0 control, 1 counter, 2 modulo and 3 reserved, which reads 0x00. The control byte reads back as {flag[7], source[6:5], irq_enable[4], prescale_code[3:0]}.
- R3: Source 00 takes the low-power strobe and 01 takes the external strobe. Source 1x (10 or 11) takes the internal strobe. Strobes on sources that are not selected have no effect.
- R4: Prescale codes 1 to 7 give one counter advance every 2^(code+2) selected strobes, that is every 8 to 512 strobes.
- R5: Prescale codes 8 to 15 give one advance every 1, 2, 5, 10, 20, 50, 100 or 1000 strobes, in that order.
- R6: Prescale code 0 stops the block, and the counter and prescaler stay at 0.
- R7: On an advance the counter adds 1. An advance that finds the counter equal to the modulo value sets it to 0 instead and sets the flag.
- R8: With modulo 0 the counter stays at 0, and every advance sets the flag.
- R9: Writing control with bit 7 = 1 clears the flag, and writing bit 7 = 0 leaves it unchanged. Software cannot set the flag. If a match and a clearing write happen in the same cycle, the match wins.
- R10: irq is 1 exactly while the flag and irq_enable are both 1.
- R11: A write to modulo, or a control write that changes the prescale code, sets the counter and the prescaler to 0 and cancels any advance in that cycle. A control write that keeps the code leaves both unchanged.
- R12: Writes to the counter address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_lp | input | 1 | Low-power tick strobe |
| tick_ext | input | 1 | External tick strobe |
| tick_int | input | 1 | Internal fast tick strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A prescaler stuck one count off shows up at the counter port only after a full divide period. For this reason the bench applies exactly divisor-1 strobes and checks that the counter has not moved, then applies one more strobe and checks that it has. A wrong wrap or a missed flag set is visible on the control read and on irq in the cycle after the matching advance. A missing restart shows in the first read after a modulo write or a code change.

// File: rtl/rtick_pkg.sv
// Shared constants for the tick counter: register addresses, control field
// positions and the prescale terminal-count function.
// Assumes an 8-bit bus and a 4-bit prescale code.
package rtick_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int PS_W   = 4;
    localparam int PRE_W  = 10;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_MOD  = 2'd2;

    localparam int BIT_FLAG = 7;
    localparam int BIT_IE   = 4;

    // Terminal prescaler count (divisor minus one) for a prescale code
    function automatic logic [PRE_W-1:0] term_for(input logic [PS_W-1:0] code);
        int d;
        if (code < PS_W'(8)) begin
            d = (1 << (int'(code) + 2));
        end else begin
            case (code[2:0])
                3'd0:    d = 1;
                3'd1:    d = 2;
                3'd2:    d = 5;
                3'd3:    d = 10;
                3'd4:    d = 20;
                3'd5:    d = 50;
                3'd6:    d = 100;
                default: d = 1000;
            endcase
        end
        return PRE_W'(d - 1);
    endfunction
endpackage

// File: rtl/rtick_regs.sv
// Control and modulo registers with the sticky match flag.
// Produces a restart pulse on a modulo write or on a prescale code change.
// Assumes set_flag comes from the counter in the same cycle.
module rtick_regs
    import rtick_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int PW = PS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          set_flag,
    output logic          flag,
    output logic [1:0]    src,
    output logic          ie,
    output logic [PW-1:0] ps,
    output logic [DW-1:0] modv,
    output logic          restart
);
    logic wr_ctrl, wr_mod;

    // Decode the register targets of a bus write
    always_comb begin
        wr_ctrl = wr && (addr == ADR_CTRL);
        wr_mod  = wr && (addr == ADR_MOD);
        restart = wr_mod || (wr_ctrl && (wdata[PW-1:0] != ps));
    end

    // Hold the control fields written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src <= '0;
            ie  <= 1'b0;
            ps  <= '0;
        end else if (wr_ctrl) begin
            src <= wdata[6:5];
            ie  <= wdata[BIT_IE];
            ps  <= wdata[PW-1:0];
        end
    end

    // Hold the modulo value, which resets to all ones
    always_ff @(posedge clk) begin
        if (!rst_n)      modv <= '1;
        else if (wr_mod) modv <= wdata;
    end

    // Sticky flag: a match sets it, a write-one clears it, the match wins
    always_ff @(posedge clk) begin
        if (!rst_n)                          flag <= 1'b0;
        else if (set_flag)                   flag <= 1'b1;
        else if (wr_ctrl && wdata[BIT_FLAG]) flag <= 1'b0;
    end
endmodule

// File: rtl/rtick_prescale.sv
// Source selection and programmable prescaler.
// Emits a one-cycle advance pulse at the end of each divide period.
// Assumes strobes are single-cycle enables in the system clock domain.
module rtick_prescale
    import rtick_pkg::*;
#(
    parameter int PW = PS_W,
    parameter int QW = PRE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_lp,
    input  logic          tick_ext,
    input  logic          tick_int,
    input  logic [1:0]    src,
    input  logic [PW-1:0] ps,
    input  logic          restart,
    output logic          inc
);
    logic          strobe;
    logic          run;
    logic [QW-1:0] pcnt;
    logic [QW-1:0] term;

    // Pick the strobe named by the source field (1x is the internal one)
    always_comb begin
        if (src[1])      strobe = tick_int;
        else if (src[0]) strobe = tick_ext;
        else             strobe = tick_lp;
        run  = (ps != '0) && !restart;
        term = term_for(ps);
        inc  = run && strobe && (pcnt == term);
    end

    // Count selected strobes up to the terminal value
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pcnt <= '0;
        else if (strobe)    pcnt <= (pcnt == term) ? '0 : pcnt + 1'b1;
    end
endmodule

// File: rtl/rtick_count.sv
// The up counter with modulo compare. A restart has priority over an advance.
// Assumes inc is already low whenever restart is high.
module rtick_count #(
    parameter int DW = rtick_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          restart,
    input  logic [DW-1:0] modv,
    output logic [DW-1:0] cnt,
    output logic          match
);
    // A match is an advance that finds the counter at the modulo value
    always_comb match = inc && (cnt == modv);

    // Advance, wrap on match, clear on restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (match)        cnt <= '0;
        else if (inc)          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rtick_timer.sv
// Top level of the modulo tick counter: bus read mux, register block,
// prescaler and counter. Read data is combinational from the address.
module rtick_timer
    import rtick_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int PW = PS_W,
    parameter int QW = PRE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_lp,
    input  logic          tick_ext,
    input  logic          tick_int,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    logic          flag, ie, restart, inc, match;
    logic [1:0]    src;
    logic [PW-1:0] ps;
    logic [DW-1:0] modv, cnt;

    rtick_regs #(.DW(DW), .AW(AW), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .set_flag(match), .flag(flag), .src(src),
        .ie(ie), .ps(ps), .modv(modv), .restart(restart)
    );

    rtick_prescale #(.PW(PW), .QW(QW)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_lp(tick_lp), .tick_ext(tick_ext),
        .tick_int(tick_int), .src(src), .ps(ps), .restart(restart), .inc(inc)
    );

    rtick_count #(.DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc), .restart(restart),
        .modv(modv), .cnt(cnt), .match(match)
    );

    // Read mux and interrupt output
    always_comb begin
        case (bus_addr)
            ADR_CTRL: bus_rdata = {flag, src, ie, ps};
            ADR_CNT:  bus_rdata = cnt;
            ADR_MOD:  bus_rdata = modv;
            default:  bus_rdata = '0;
        endcase
        irq = flag && ie;
    end
endmodule

// File: rtl/rtick_chk.sv
// Assertion checker for rtick_timer, attached by bind.
module rtick_chk #(
    parameter int DW = 8,
    parameter int AW = 2,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr,
    input logic [AW-1:0] addr,
    input logic          wbit7,
    input logic          irq,
    input logic          flag,
    input logic          ie,
    input logic [PW-1:0] ps,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] modv,
    input logic          inc,
    input logic          restart
);
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) irq == (flag && ie)); // R10
    AST_HALT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (ps == '0) |-> (cnt == '0 && !inc)); // R6
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (inc && cnt == modv) |=> (flag && cnt == '0)); // R7
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n) (inc && cnt != modv) |=> (cnt == $past(cnt) + 1'b1)); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= modv); // R7
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n) (wr && addr == '0 && wbit7 && !(inc && cnt == modv)) |=> !flag); // R9
    AST_CNT_RO: assert property (@(posedge clk) disable iff (!rst_n) (wr && addr == AW'(1) && !inc && !restart) |=> $stable(cnt)); // R12
    AST_RESTART_CLR: assert property (@(posedge clk) disable iff (!rst_n) restart |=> (cnt == '0)); // R11
endmodule

bind rtick_timer rtick_chk #(.DW(DW), .AW(AW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wbit7(bus_wdata[7]), .irq(irq), .flag(flag), .ie(ie), .ps(ps),
    .cnt(cnt), .modv(modv), .inc(inc), .restart(restart)
);

// File: tb/sim_rtick_timer.sv
module sim_rtick_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_lp = 1'b0, tick_ext = 1'b0, tick_int = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    int         total = 0;
    int         bad = 0;

    always #10 clk = ~clk; // 50 MHz

    rtick_timer u0 (.*);

    // Vector kinds: 0 write, 1 strobe source addr (0 lp, 1 ext, 2 int) n times,
    // 2 read addr and expect data, 3 expect irq == data[0]
    localparam int NV = 82;
    localparam logic [27:0] VEC [NV] = '{
        {2'd2,2'd0,8'h00,12'd0,4'd1},  {2'd2,2'd1,8'h00,12'd0,4'd1},   // R1
        {2'd2,2'd2,8'hFF,12'd0,4'd1},  {2'd3,2'd0,8'h00,12'd0,4'd1},   // R1
        {2'd0,2'd0,8'h08,12'd0,4'd3},  {2'd1,2'd0,8'h00,12'd5,4'd3},   // R3 lp
        {2'd2,2'd1,8'h05,12'd0,4'd3},  {2'd1,2'd1,8'h00,12'd3,4'd3},   // R3
        {2'd1,2'd2,8'h00,12'd3,4'd3},  {2'd2,2'd1,8'h05,12'd0,4'd3},   // R3 others ignored
        {2'd0,2'd0,8'h28,12'd0,4'd11}, {2'd1,2'd1,8'h00,12'd2,4'd3},   // R11 same code
        {2'd2,2'd1,8'h07,12'd0,4'd3},  {2'd0,2'd0,8'h48,12'd0,4'd3},   // R3 ext
        {2'd1,2'd2,8'h00,12'd1,4'd3},  {2'd2,2'd1,8'h08,12'd0,4'd3},   // R3 src 10
        {2'd0,2'd0,8'h68,12'd0,4'd3},  {2'd1,2'd2,8'h00,12'd1,4'd3},   // R3 src 11
        {2'd2,2'd1,8'h09,12'd0,4'd3},  {2'd2,2'd0,8'h68,12'd0,4'd2},   // R2
        {2'd0,2'd2,8'h03,12'd0,4'd11}, {2'd2,2'd1,8'h00,12'd0,4'd11},  // R11 mod write
        {2'd2,2'd2,8'h03,12'd0,4'd2},  {2'd1,2'd2,8'h00,12'd3,4'd7},   // R7
        {2'd2,2'd1,8'h03,12'd0,4'd7},  {2'd2,2'd0,8'h68,12'd0,4'd7},   // R7 no flag yet
        {2'd1,2'd2,8'h00,12'd1,4'd7},  {2'd2,2'd1,8'h00,12'd0,4'd7},   // R7 wrap
        {2'd2,2'd0,8'hE8,12'd0,4'd7},  {2'd3,2'd0,8'h00,12'd0,4'd10},  // R7 flag, R10
        {2'd0,2'd0,8'h78,12'd0,4'd9},  {2'd2,2'd0,8'hF8,12'd0,4'd9},   // R9 write 0 keeps
        {2'd3,2'd0,8'h01,12'd0,4'd10}, {2'd0,2'd0,8'hF8,12'd0,4'd9},   // R10
        {2'd2,2'd0,8'h78,12'd0,4'd9},  {2'd3,2'd0,8'h00,12'd0,4'd10},  // R9 clear
        {2'd1,2'd2,8'h00,12'd2,4'd12}, {2'd0,2'd1,8'h55,12'd0,4'd12},  // R12
        {2'd2,2'd1,8'h02,12'd0,4'd12}, {2'd0,2'd0,8'h61,12'd0,4'd11},  // R12, R11
        {2'd2,2'd1,8'h00,12'd0,4'd11}, {2'd1,2'd2,8'h00,12'd7,4'd4},   // R4 div 8
        {2'd2,2'd1,8'h00,12'd0,4'd4},  {2'd1,2'd2,8'h00,12'd1,4'd4},
        {2'd2,2'd1,8'h01,12'd0,4'd4},  {2'd0,2'd0,8'h67,12'd0,4'd4},   // R4 div 512
        {2'd1,2'd2,8'h00,12'd511,4'd4},{2'd2,2'd1,8'h00,12'd0,4'd4},
        {2'd1,2'd2,8'h00,12'd1,4'd4},  {2'd2,2'd1,8'h01,12'd0,4'd4},
        {2'd0,2'd0,8'h6A,12'd0,4'd5},  {2'd1,2'd2,8'h00,12'd4,4'd5},   // R5 div 5
        {2'd2,2'd1,8'h00,12'd0,4'd5},  {2'd1,2'd2,8'h00,12'd1,4'd5},
        {2'd2,2'd1,8'h01,12'd0,4'd5},  {2'd0,2'd0,8'h6F,12'd0,4'd5},   // R5 div 1000
        {2'd1,2'd2,8'h00,12'd999,4'd5},{2'd2,2'd1,8'h00,12'd0,4'd5},
        {2'd1,2'd2,8'h00,12'd1,4'd5},  {2'd2,2'd1,8'h01,12'd0,4'd5},
        {2'd0,2'd0,8'h6A,12'd0,4'd11}, {2'd1,2'd2,8'h00,12'd3,4'd11},  // R11 prescaler
        {2'd0,2'd2,8'h0A,12'd0,4'd11}, {2'd1,2'd2,8'h00,12'd4,4'd11},
        {2'd2,2'd1,8'h00,12'd0,4'd11}, {2'd1,2'd2,8'h00,12'd1,4'd11},
        {2'd2,2'd1,8'h01,12'd0,4'd11}, {2'd0,2'd0,8'h60,12'd0,4'd6},   // R6
        {2'd1,2'd2,8'h00,12'd50,4'd6}, {2'd2,2'd1,8'h00,12'd0,4'd6},
        {2'd0,2'd0,8'h68,12'd0,4'd6},  {2'd1,2'd2,8'h00,12'd1,4'd6},
        {2'd2,2'd1,8'h01,12'd0,4'd6},  {2'd0,2'd2,8'h00,12'd0,4'd8},   // R8
        {2'd1,2'd2,8'h00,12'd3,4'd8},  {2'd2,2'd1,8'h00,12'd0,4'd8},
        {2'd2,2'd0,8'hE8,12'd0,4'd8},  {2'd0,2'd0,8'hE8,12'd0,4'd9},   // R9
        {2'd2,2'd0,8'h68,12'd0,4'd9},  {2'd2,2'd3,8'h00,12'd0,4'd2},   // R2 reserved
        {2'd0,2'd0,8'hE8,12'd0,4'd9},  {2'd2,2'd0,8'h68,12'd0,4'd9}    // R9 no set by sw
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input string req, input logic [1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic do_strobe(input logic [1:0] s, input int n);
        tick_lp = (s == 2'd0); tick_ext = (s == 2'd1); tick_int = (s == 2'd2);
        repeat (n) @(negedge clk);
        tick_lp = 1'b0; tick_ext = 1'b0; tick_int = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  k, a;
            logic [7:0]  d;
            logic [11:0] n;
            logic [3:0]  r;
            {k, a, d, n, r} = VEC[i];
            case (k)
                2'd0: do_write(a, d);
                2'd1: do_strobe(a, int'(n));
                2'd2: do_read($sformatf("R%0d vec%0d", r, i), a, d);
                default: begin
                    #1;
                    check($sformatf("R%0d vec%0d irq", r, i), {7'd0, irq}, d);
                end
            endcase
        end

        // R9: match and clearing write in the same cycle, the match wins (mod 0, ps 8)
        tick_int = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'hE8;
        @(negedge clk);
        tick_int = 1'b0; bus_wr = 1'b0;
        do_read("R9 set wins", 2'd0, 8'hE8);

        // R1: reset in the middle of a run restores every register
        do_write(2'd2, 8'h05);
        do_write(2'd0, 8'h18);
        do_strobe(2'd0, 3);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_read("R1 ctrl", 2'd0, 8'h00);
        do_read("R1 cnt", 2'd1, 8'h00);
        do_read("R1 mod", 2'd2, 8'hFF);
        check("R1 irq", {7'd0, irq}, 8'h00);
        finish_run();
    end
endmodule